// File: doc/BRIEF.md
# Precise Exception Commit Unit

This block decides, for a five-stage in-order pipeline, when control flow leaves the program for the trap handler and when it comes back. Each instruction carries a valid bit, its PC and at most one pending fault code as it moves through decode, execute and memory. Four stages can raise a fault against the instruction they hold: fetch (instruction address fault), decode (illegal opcode), execute (overflow) and memory (data address fault). A fault is only recorded against the instruction. No action is taken until the instruction reaches the memory stage, which is the single commit point.

At the commit point the unit also samples the external interrupt request. It then makes one of three choices:
- Retire the instruction normally.
- Take a trap. The unit records the PC and a cause code, masks interrupts, enters kernel mode, flushes every younger instruction, suppresses writeback and steers fetch to a fixed handler address.
- Honour a return-from-exception. The unit unmasks interrupts, leaves kernel mode and steers fetch back to the saved PC.

Architectural side effects happen only at commit, so the flushed instructions leave nothing behind.

Top module: `exc_commit_unit`

## Requirements
- R1: After reset the saved PC (`epc`) is 0, `cause` is 0, `irq_en` is 0 and `kernel_mode` is 1. `commit_valid`, `kill_wb` and `redirect_valid` stay low until an instruction reaches commit.
- R2: A fault-free instruction accepted with `if_valid` at clock edge N is at commit during the cycle after edges N+1 and N+2. While it is at commit, `commit_valid` is 1 and `commit_pc` equals its PC. Back-to-back instructions retire in order, one per cycle.
- R3: An instruction with a single fault traps at commit. On the following edge `epc` takes its PC and `cause` takes the fault code. The codes are: fetch address fault = 0, illegal opcode = 1, overflow = 2, data address fault = 3.
- R4: When one instruction collects several faults, the recorded cause is the one raised in the earliest stage (fetch before decode before execute before memory).
- R5: When `irq_en` is 1, an `irq_req` seen while a valid instruction is at commit traps with cause 8, even if that instruction also has a fault. `epc` records that instruction's PC.
- R6: `irq_req` has no effect while `irq_en` is 0 or while the commit stage holds no valid instruction.
- R7: In a trap cycle, `kill_wb` is 1, `commit_valid` is 0, `redirect_valid` is 1 and `redirect_pc` is `HANDLER_PC`. After the edge, `irq_en` is 0 and `kernel_mode` is 1.
- R8: A redirect kills every younger instruction: those in decode and execute, and the one presented on `if_valid` in the same cycle. None of them ever shows `commit_valid`, and the cycle after a redirect has nothing at commit.
- R9: A valid, non-trapping instruction at commit with `mem_eret` high produces `commit_valid` = 1, `redirect_valid` = 1 and `redirect_pc` = `epc`. After the edge, `irq_en` is 1 and `kernel_mode` is 0.
- R10: A stage with no valid instruction carries no fault. Fault inputs and `mem_eret` asserted against an empty stage never cause a trap or a redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_valid | input | 1 | Fetch presents an instruction to decode this cycle |
| if_pc | input | PCW | PC of the fetched instruction |
| if_addr_fault | input | 1 | Fetch address fault for the fetched instruction |
| id_illegal | input | 1 | Illegal opcode for the instruction now in decode |
| ex_overflow | input | 1 | Arithmetic overflow for the instruction now in execute |
| mem_addr_fault | input | 1 | Data address fault for the instruction now in memory |
| mem_eret | input | 1 | Instruction now in memory is a return-from-exception |
| irq_req | input | 1 | External interrupt request level |
| commit_valid | output | 1 | Instruction at commit retires and may write back |
| commit_pc | output | PCW | PC of the instruction at commit |
| kill_wb | output | 1 | Trap taken: suppress writeback of the commit instruction |
| redirect_valid | output | 1 | Flush all younger stages and load fetch with `redirect_pc` |
| redirect_pc | output | PCW | Handler address on a trap, saved PC on a return |
| epc | output | PCW | PC saved by the last trap |
| cause | output | 4 | Cause code of the last trap |
| irq_en | output | 1 | Interrupts enabled |
| kernel_mode | output | 1 | Privileged mode flag |

## Verification
A stale fault code inside the decode or execute register surfaces as a trap on a clean instruction, or as a wrong `cause`. This shows at most two cycles after the code was left behind, when the instruction carrying it reaches commit. A valid bit that survives a flush shows as `commit_valid` in the cycle right after a redirect. A corrupted interrupt mask or mode bit shows as a taken or missed interrupt on the next committing instruction. The reference model compares every output on every cycle, so each of these faults is reported in the cycle it first reaches a port.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int unsigned CAUSE_W = 4;

  localparam logic [CAUSE_W-1:0] CAUSE_IFETCH  = 4'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = 4'd1;
  localparam logic [CAUSE_W-1:0] CAUSE_OVF     = 4'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_DADDR   = 4'd3;
  localparam logic [CAUSE_W-1:0] CAUSE_IRQ     = 4'd8;

  // number of pipeline registers between fetch and commit
  localparam int unsigned NUM_STAGES = 3;

  // fault code contributed while entering stage register idx
  function automatic logic [CAUSE_W-1:0] entry_code(input int idx);
    case (idx)
      0:       entry_code = CAUSE_IFETCH;
      1:       entry_code = CAUSE_ILLEGAL;
      default: entry_code = CAUSE_OVF;
    endcase
  endfunction

endpackage

// File: rtl/exc_pipe_stage.sv
module exc_pipe_stage
  import exc_pkg::*;
#(
  parameter int unsigned          PCW        = 32,
  parameter logic [CAUSE_W-1:0]   LOCAL_CODE = 4'd0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               in_valid,
  input  logic [PCW-1:0]     in_pc,
  input  logic               in_exc,
  input  logic [CAUSE_W-1:0] in_code,
  input  logic               local_fault,
  output logic               out_valid,
  output logic [PCW-1:0]     out_pc,
  output logic               out_exc,
  output logic [CAUSE_W-1:0] out_code
);

  logic               valid_d, valid_q;
  logic               exc_d, exc_q;
  logic [CAUSE_W-1:0] code_d, code_q;
  logic [PCW-1:0]     pc_q;
  logic               pc_en;

  // next state: a flushed or empty slot holds no fault; an older fault wins
  always_comb begin
    valid_d = in_valid && !flush;
    exc_d   = 1'b0;
    code_d  = '0;
    if (valid_d) begin
      if (in_exc) begin
        exc_d  = 1'b1;
        code_d = in_code;
      end else if (local_fault) begin
        exc_d  = 1'b1;
        code_d = LOCAL_CODE;
      end
    end
    pc_en = valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      exc_q   <= 1'b0;
      code_q  <= '0;
    end else begin
      valid_q <= valid_d;
      exc_q   <= exc_d;
      code_q  <= code_d;
    end
  end

  // data register: no reset, loaded only when a live instruction enters
  always_ff @(posedge clk) begin
    if (pc_en) begin
      pc_q <= in_pc;
    end
  end

  assign out_valid = valid_q;
  assign out_pc    = pc_q;
  assign out_exc   = exc_q;
  assign out_code  = code_q;

endmodule

// File: rtl/exc_commit_ctrl.sv
module exc_commit_ctrl
  import exc_pkg::*;
#(
  parameter int unsigned    PCW        = 32,
  parameter logic [PCW-1:0] HANDLER_PC = 32'h0000_0080
) (
  input  logic               m_valid,
  input  logic               m_exc,
  input  logic [CAUSE_W-1:0] m_code,
  input  logic               mem_addr_fault,
  input  logic               mem_eret,
  input  logic               irq_req,
  input  logic               irq_en,
  input  logic [PCW-1:0]     epc,
  output logic               trap,
  output logic [CAUSE_W-1:0] trap_cause,
  output logic               eret_go,
  output logic               redirect_valid,
  output logic [PCW-1:0]     redirect_pc,
  output logic               commit_valid,
  output logic               kill_wb
);

  logic take_irq;
  logic take_exc;

  always_comb begin
    take_irq = m_valid && irq_req && irq_en;
    take_exc = m_valid && (m_exc || mem_addr_fault);
    trap     = take_irq || take_exc;

    // interrupt first, then the oldest carried fault, then the memory fault
    if (take_irq) begin
      trap_cause = CAUSE_IRQ;
    end else if (m_exc) begin
      trap_cause = m_code;
    end else begin
      trap_cause = CAUSE_DADDR;
    end

    eret_go        = m_valid && mem_eret && !trap;
    redirect_valid = trap || eret_go;
    redirect_pc    = trap ? HANDLER_PC : epc;
    commit_valid   = m_valid && !trap;
    kill_wb        = trap;
  end

endmodule

// File: rtl/exc_status_regs.sv
module exc_status_regs
  import exc_pkg::*;
#(
  parameter int unsigned PCW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic [PCW-1:0]     trap_pc,
  input  logic               eret_go,
  output logic [PCW-1:0]     epc,
  output logic [CAUSE_W-1:0] cause,
  output logic               irq_en,
  output logic               kernel_mode
);

  logic [PCW-1:0]     epc_d, epc_q;
  logic [CAUSE_W-1:0] cause_d, cause_q;
  logic               ie_d, ie_q;
  logic               km_d, km_q;
  logic               save_en;
  logic               mode_en;

  always_comb begin
    save_en = trap;
    mode_en = trap || eret_go;
    epc_d   = save_en ? trap_pc    : epc_q;
    cause_d = save_en ? trap_cause : cause_q;
    ie_d    = ie_q;
    km_d    = km_q;
    if (mode_en) begin
      ie_d = !trap;
      km_d = trap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q   <= '0;
      cause_q <= '0;
      ie_q    <= 1'b0;
      km_q    <= 1'b1;
    end else begin
      epc_q   <= epc_d;
      cause_q <= cause_d;
      ie_q    <= ie_d;
      km_q    <= km_d;
    end
  end

  assign epc         = epc_q;
  assign cause       = cause_q;
  assign irq_en      = ie_q;
  assign kernel_mode = km_q;

endmodule

// File: rtl/exc_commit_unit.sv
module exc_commit_unit
  import exc_pkg::*;
#(
  parameter int unsigned    PCW        = 32,
  parameter logic [PCW-1:0] HANDLER_PC = 32'h0000_0080
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           if_valid,
  input  logic [PCW-1:0] if_pc,
  input  logic           if_addr_fault,
  input  logic           id_illegal,
  input  logic           ex_overflow,
  input  logic           mem_addr_fault,
  input  logic           mem_eret,
  input  logic           irq_req,
  output logic           commit_valid,
  output logic [PCW-1:0] commit_pc,
  output logic           kill_wb,
  output logic           redirect_valid,
  output logic [PCW-1:0] redirect_pc,
  output logic [PCW-1:0] epc,
  output logic [3:0]     cause,
  output logic           irq_en,
  output logic           kernel_mode
);

  // index 0 is the fetch side; index NUM_STAGES is the commit stage
  logic               st_valid [NUM_STAGES+1];
  logic [PCW-1:0]     st_pc    [NUM_STAGES+1];
  logic               st_exc   [NUM_STAGES+1];
  logic [CAUSE_W-1:0] st_code  [NUM_STAGES+1];
  logic               st_fault [NUM_STAGES];

  logic               flush;
  logic               trap;
  logic [CAUSE_W-1:0] trap_cause;
  logic               eret_go;

  assign st_valid[0] = if_valid;
  assign st_pc[0]    = if_pc;
  assign st_exc[0]   = 1'b0;
  assign st_code[0]  = '0;

  // fault raised against the instruction entering each register
  assign st_fault[0] = if_addr_fault;
  assign st_fault[1] = id_illegal;
  assign st_fault[2] = ex_overflow;

  assign flush = redirect_valid;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    exc_pipe_stage #(
      .PCW        (PCW),
      .LOCAL_CODE (entry_code(g))
    ) u_stage (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush       (flush),
      .in_valid    (st_valid[g]),
      .in_pc       (st_pc[g]),
      .in_exc      (st_exc[g]),
      .in_code     (st_code[g]),
      .local_fault (st_fault[g]),
      .out_valid   (st_valid[g+1]),
      .out_pc      (st_pc[g+1]),
      .out_exc     (st_exc[g+1]),
      .out_code    (st_code[g+1])
    );
  end

  exc_commit_ctrl #(
    .PCW        (PCW),
    .HANDLER_PC (HANDLER_PC)
  ) u_ctrl (
    .m_valid        (st_valid[NUM_STAGES]),
    .m_exc          (st_exc[NUM_STAGES]),
    .m_code         (st_code[NUM_STAGES]),
    .mem_addr_fault (mem_addr_fault),
    .mem_eret       (mem_eret),
    .irq_req        (irq_req),
    .irq_en         (irq_en),
    .epc            (epc),
    .trap           (trap),
    .trap_cause     (trap_cause),
    .eret_go        (eret_go),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .commit_valid   (commit_valid),
    .kill_wb        (kill_wb)
  );

  exc_status_regs #(
    .PCW (PCW)
  ) u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .trap        (trap),
    .trap_cause  (trap_cause),
    .trap_pc     (st_pc[NUM_STAGES]),
    .eret_go     (eret_go),
    .epc         (epc),
    .cause       (cause),
    .irq_en      (irq_en),
    .kernel_mode (kernel_mode)
  );

  assign commit_pc = st_pc[NUM_STAGES];

endmodule

// File: rtl/exc_commit_chk.sv
module exc_commit_chk #(
  parameter int unsigned    PCW        = 32,
  parameter logic [PCW-1:0] HANDLER_PC = 32'h0000_0080
) (
  input logic           clk,
  input logic           rst_n,
  input logic           irq_req,
  input logic           irq_en,
  input logic           kernel_mode,
  input logic           kill_wb,
  input logic           redirect_valid,
  input logic [PCW-1:0] redirect_pc,
  input logic           commit_valid,
  input logic [3:0]     cause,
  input logic           m_valid,
  input logic           m_exc,
  input logic           mem_addr_fault
);

  // R7
  trap_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill_wb |-> (redirect_valid && redirect_pc == HANDLER_PC && !commit_valid));

  // R7
  trap_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill_wb |=> (!irq_en && kernel_mode));

  // R9
  eret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && !kill_wb) |=> (irq_en && !kernel_mode));

  // R5
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_wb && irq_req && irq_en) |=> (cause == 4'd8));

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!m_exc && !(m_valid && mem_addr_fault) && (!irq_en || !m_valid)) |-> !kill_wb);

  // R8
  flush_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> (!commit_valid && !kill_wb));

endmodule

bind exc_commit_unit exc_commit_chk #(
  .PCW        (PCW),
  .HANDLER_PC (HANDLER_PC)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .irq_req        (irq_req),
  .irq_en         (irq_en),
  .kernel_mode    (kernel_mode),
  .kill_wb        (kill_wb),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .commit_valid   (commit_valid),
  .cause          (cause),
  .m_valid        (st_valid[3]),
  .m_exc          (st_exc[3]),
  .mem_addr_fault (mem_addr_fault)
);

// File: tb/test_exc_commit_unit.sv
`timescale 1ns/1ps
module test_exc_commit_unit;

  localparam int unsigned    PCW = 32;
  localparam logic [PCW-1:0] HPC = 32'h0000_0080;

  typedef struct {
    logic [PCW-1:0] pc;
    bit f0, f1, f2, f3, er;
  } rec_t;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           if_valid, if_addr_fault, id_illegal, ex_overflow;
  logic           mem_addr_fault, mem_eret, irq_req;
  logic [PCW-1:0] if_pc;
  logic           commit_valid, kill_wb, redirect_valid, irq_en, kernel_mode;
  logic [PCW-1:0] commit_pc, redirect_pc, epc;
  logic [3:0]     cause;

  always #2 clk = ~clk;

  exc_commit_unit #(.PCW(PCW), .HANDLER_PC(HPC)) i_exc_commit_unit (
    .clk(clk), .rst_n(rst_n), .if_valid(if_valid), .if_pc(if_pc),
    .if_addr_fault(if_addr_fault), .id_illegal(id_illegal),
    .ex_overflow(ex_overflow), .mem_addr_fault(mem_addr_fault),
    .mem_eret(mem_eret), .irq_req(irq_req), .commit_valid(commit_valid),
    .commit_pc(commit_pc), .kill_wb(kill_wb), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .epc(epc), .cause(cause), .irq_en(irq_en),
    .kernel_mode(kernel_mode)
  );

  int    checks = 0;
  int    failures = 0;
  bit    done = 0;
  string cur_req = "R1";

  // reference model: in-flight records per stage plus status state
  rec_t           md, me, mm;
  bit             vd, ve, vm;
  logic [PCW-1:0] m_epc;
  logic [3:0]     m_cause;
  bit             m_ie, m_km;
  logic [PCW-1:0] next_pc = 32'h100;

  task automatic check(input string what, input logic [PCW-1:0] act, input logic [PCW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", what, cur_req, act, exp);
    end
  endtask

  task automatic step(input bit fv, input rec_t fr, input bit irq_i, input bit junk);
    bit             e_irq, e_exc, e_trap, e_eret;
    logic [3:0]     e_code;
    @(negedge clk);
    if_valid       = fv;
    if_pc          = fr.pc;
    if_addr_fault  = fv ? fr.f0 : junk;
    id_illegal     = vd ? md.f1 : junk;
    ex_overflow    = ve ? me.f2 : junk;
    mem_addr_fault = vm ? mm.f3 : junk;
    mem_eret       = vm ? mm.er : junk;
    irq_req        = irq_i;
    #1;
    e_irq  = vm && irq_i && m_ie;
    e_exc  = vm && (mm.f0 || mm.f1 || mm.f2 || mm.f3);
    e_trap = e_irq || e_exc;
    e_eret = vm && mm.er && !e_trap;
    e_code = e_irq ? 4'd8 : mm.f0 ? 4'd0 : mm.f1 ? 4'd1 : mm.f2 ? 4'd2 : 4'd3;
    check("R2 commit_valid", commit_valid, vm && !e_trap);
    if (vm && !e_trap) check("R2 commit_pc", commit_pc, mm.pc);
    check("R7 kill_wb", kill_wb, e_trap);
    check("R7/R9 redirect_valid", redirect_valid, e_trap || e_eret);
    if (e_trap || e_eret) check("R7/R9 redirect_pc", redirect_pc, e_trap ? HPC : m_epc);
    check("R3 epc", epc, m_epc);
    check("R3/R4 cause", cause, m_cause);
    check("R7/R9 irq_en", irq_en, m_ie);
    check("R7/R9 kernel_mode", kernel_mode, m_km);
    if (e_trap) begin
      m_epc = mm.pc; m_cause = e_code; m_ie = 0; m_km = 1;
    end else if (e_eret) begin
      m_ie = 1; m_km = 0;
    end
    if (e_trap || e_eret) begin
      vd = 0; ve = 0; vm = 0;
    end else begin
      vm = ve; mm = me; ve = vd; me = md; vd = fv; md = fr;
    end
  endtask

  task automatic issue(input bit f0, input bit f1, input bit f2, input bit f3,
                       input bit er, input bit irq_i);
    rec_t r;
    r.pc = next_pc; r.f0 = f0; r.f1 = f1; r.f2 = f2; r.f3 = f3; r.er = er;
    next_pc = next_pc + 4;
    step(1'b1, r, irq_i, 1'b0);
  endtask

  task automatic bubble(input int n, input bit irq_i, input bit junk);
    rec_t r;
    r.pc = '0; r.f0 = 0; r.f1 = 0; r.f2 = 0; r.f3 = 0; r.er = 0;
    for (int i = 0; i < n; i++) step(1'b0, r, irq_i, junk);
  endtask

  // handler body: one return instruction at the handler address, then drain
  task automatic handler_return(input bit irq_i);
    rec_t r;
    r.pc = HPC; r.f0 = 0; r.f1 = 0; r.f2 = 0; r.f3 = 0; r.er = 1;
    step(1'b1, r, irq_i, 1'b0);
    bubble(3, irq_i, 1'b0);
  endtask

  initial begin
    rst_n = 0; if_valid = 0; if_pc = '0; if_addr_fault = 0; id_illegal = 0;
    ex_overflow = 0; mem_addr_fault = 0; mem_eret = 0; irq_req = 0;
    vd = 0; ve = 0; vm = 0; m_epc = '0; m_cause = '0; m_ie = 0; m_km = 1;
    md = '{default: 0}; me = '{default: 0}; mm = '{default: 0};
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    check("R1 epc", epc, '0);
    check("R1 cause", cause, '0);
    check("R1 irq_en", irq_en, 1'b0);
    check("R1 kernel_mode", kernel_mode, 1'b1);
    check("R1 commit_valid", commit_valid, 1'b0);
    check("R1 redirect_valid", redirect_valid, 1'b0);

    cur_req = "R2";
    for (int i = 0; i < 6; i++) issue(0, 0, 0, 0, 0, 0);
    bubble(3, 0, 0);

    cur_req = "R9 R8";
    issue(0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 3; i++) issue(0, 0, 0, 0, 0, 0);
    bubble(3, 0, 0);

    for (int c = 0; c < 4; c++) begin
      cur_req = "R3 R8";
      issue(c == 0, c == 1, c == 2, c == 3, 0, 0);
      for (int i = 0; i < 3; i++) issue(0, 0, 0, 0, 0, 0);
      bubble(2, 0, 0);
      handler_return(0);
    end

    cur_req = "R4";
    issue(0, 1, 1, 1, 0, 0);
    bubble(3, 0, 0);
    handler_return(0);
    issue(1, 0, 0, 1, 0, 0);
    bubble(3, 0, 0);
    handler_return(0);
    issue(0, 0, 1, 1, 1, 0);
    bubble(3, 0, 0);
    handler_return(0);

    cur_req = "R5";
    issue(0, 0, 1, 0, 0, 1);
    bubble(3, 1, 0);
    cur_req = "R6";
    handler_return(1);
    bubble(3, 1, 0);
    issue(0, 0, 0, 0, 0, 0);
    bubble(3, 0, 0);

    cur_req = "R10";
    bubble(5, 0, 1);
    issue(0, 0, 0, 0, 0, 0);
    bubble(1, 0, 1);
    issue(0, 0, 0, 0, 0, 0);
    bubble(4, 0, 1);

    cur_req = "R2 R3 R4 R5 R6 R8 R9 R10";
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 9) < 7)
        issue($urandom_range(0, 15) == 0, $urandom_range(0, 15) == 0,
              $urandom_range(0, 15) == 0, $urandom_range(0, 15) == 0,
              $urandom_range(0, 11) == 0, $urandom_range(0, 7) == 0);
      else
        bubble(1, $urandom_range(0, 7) == 0, $urandom_range(0, 1) == 1);
    end
    bubble(4, 0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog [%s] actual=hung expected=finished", cur_req);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule